// File: doc/BRIEF.md
# Receive FIFO Watermark Status Unit

This block is the receive queue of a serial port. Words from the serial side are written in at one end. Software or a DMA engine removes them at the other end through a bus-side read port. A DMA acknowledge strobe counts as one read access, just like a bus read of the data register.

Around the queue the block keeps two status flags:
- a full flag, and
- a data-transfer request flag, which compares the fill level against a selectable watermark.

It also keeps a sticky overrun bit and drives one interrupt line, gated by a per-flag enable.

A small state machine controls the transfer request so that every DMA acknowledge produces a visible low cycle on the request. The machine has three named states:
- `REQ_OFF`: receive is disabled.
- `REQ_ARMED`: the request follows the watermark comparison.
- `REQ_HOLD`: the request is forced low for the cycle after an acknowledge.

The transitions are:
- `OFF->ARMED` when receive is enabled.
- `ARMED->HOLD` on an acknowledge.
- `HOLD->HOLD` on a further acknowledge.
- `HOLD->ARMED` when no acknowledge arrives.
- `any->OFF` when receive is disabled.

Top module: `rxq_wmark_top`

## Requirements
- R1: Accepted words are returned in arrival order. Each `rd_stb` or `dma_ack` cycle with a non-empty queue removes one word, and `rd_data` shows that word during the access. The fill level never exceeds DEPTH.
- R2: `stat[9]` (full) is 1 exactly when receive is enabled and the queue holds DEPTH words. It reads 0 after a read access removes a word.
- R3: `stat[8]` (request) is 1 when receive is enabled and the fill level is strictly greater than the threshold. The threshold is picked by `wm_sel`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives DEPTH-4. A new `wm_sel` value takes effect only after the next rising clock edge.
- R4: After an edge at which `dma_ack` is sampled high with receive enabled, `stat[8]` is 0 for the following cycle. If the fill level is still above the threshold, it reads 1 again after the next edge that has no acknowledge.
- R5: While `rx_en` is 0, `stat[9]` and `stat[8]` read 0 and writes are ignored. On the next edge the queue is flushed to empty and the overrun bit is cleared.
- R6: `irq` equals (`ie_full` AND `stat[9]`) OR (`ie_req` AND `stat[8]`).
- R7: The status word has full at bit 9, request at bit 8 and overrun at bit 0. All other bits, including the reserved bits 7 and 6, read 0.
- R8: A write to a full queue with no read in the same cycle is dropped and sets the overrun bit `stat[0]`. That bit stays set while receive is enabled.
- R9: A read access to an empty queue returns 0 and leaves the fill level unchanged.
- R10: A write and a read in the same cycle leave the fill level unchanged, even when the queue is full. In that case the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low flushes the queue |
| wm_sel | input | 2 | Watermark threshold select |
| ie_full | input | 1 | Interrupt enable for the full flag |
| ie_req | input | 1 | Interrupt enable for the request flag |
| wr_vld | input | 1 | Serial-side write strobe |
| wr_data | input | W | Serial-side write word |
| rd_stb | input | 1 | Bus read of the data register |
| dma_ack | input | 1 | DMA acknowledge, one read access |
| rd_data | output | W | Head word during a read access, else 0 |
| stat | output | 16 | Status word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench reads one word past the last entry to check R9. A design that decremented an empty count would wrap the level, so later reads would return stale words and the full flag would misbehave.

It writes into a full queue, both alone and together with a read. A design that checked fullness before the pop would either lose the paired word or fail to flag the overrun.

It pulses `dma_ack` once and then holds it for many cycles. A request that re-asserted in the same cycle would show no low gap after the acknowledge.

It changes `wm_sel` just before an edge, and drops `rx_en` with data queued and a write pending. A design that decoded `wm_sel` without a register, or that did not flush on disable, would show the wrong request value or return stale data once receive is enabled again.

// File: rtl/rxq_wmark_pkg.sv
`timescale 1ns/1ps
package rxq_wmark_pkg;

    typedef enum logic [1:0] {
        REQ_OFF   = 2'd0,
        REQ_ARMED = 2'd1,
        REQ_HOLD  = 2'd2
    } req_st_e;

    localparam int STAT_W   = 16;
    localparam int FULL_BIT = 9;
    localparam int REQ_BIT  = 8;
    localparam int OVR_BIT  = 0;

    // Threshold in entries for a watermark select code
    function automatic int wm_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return depth - 4;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 push_data,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign head = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

endmodule

// File: rtl/rxq_req_fsm.sv
`timescale 1ns/1ps
module rxq_req_fsm
    import rxq_wmark_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic above,
    input  logic ack,
    output logic req
);
    req_st_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= REQ_OFF;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!rx_en) begin
            nxt = REQ_OFF;
        end else begin
            unique case (st)
                REQ_OFF:   nxt = REQ_ARMED;
                REQ_ARMED: nxt = ack ? REQ_HOLD : REQ_ARMED;
                REQ_HOLD:  nxt = ack ? REQ_HOLD : REQ_ARMED;
                default:   nxt = REQ_OFF;
            endcase
        end
    end

    always_comb begin
        req = (st == REQ_ARMED) && above && rx_en;
    end

endmodule

// File: rtl/rxq_wmark_top.sv
`timescale 1ns/1ps
module rxq_wmark_top
    import rxq_wmark_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [1:0]        wm_sel,
    input  logic              ie_full,
    input  logic              ie_req,
    input  logic              wr_vld,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_stb,
    input  logic              dma_ack,
    output logic [W-1:0]      rd_data,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [CW-1:0] level, thr_q;
    logic [W-1:0]  head;
    logic          any_rd, pop, push, full_now, above, req, ovr_q, full_flag;

    assign any_rd   = rd_stb | dma_ack;
    assign pop      = rx_en && any_rd && (level != '0);
    assign full_now = (level == FULL_LVL);
    assign push     = rx_en && wr_vld && (!full_now || pop);
    assign above    = (level > thr_q);

    rxq_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_en),
        .push      (push),
        .pop       (pop),
        .push_data (wr_data),
        .head      (head),
        .level     (level)
    );

    rxq_req_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_en (rx_en),
        .above (above),
        .ack   (dma_ack),
        .req   (req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= CW'(wm_level(2'd0, DEPTH));
            ovr_q <= 1'b0;
        end else begin
            thr_q <= CW'(wm_level(wm_sel, DEPTH));
            if (!rx_en)                ovr_q <= 1'b0;
            else if (wr_vld && !push)  ovr_q <= 1'b1;
        end
    end

    assign full_flag = rx_en && full_now;
    assign rd_data   = pop ? head : '0;

    always_comb begin
        stat           = '0;
        stat[FULL_BIT] = full_flag;
        stat[REQ_BIT]  = req;
        stat[OVR_BIT]  = ovr_q;
    end

    assign irq = (ie_full && full_flag) || (ie_req && req);

endmodule

// File: rtl/rxq_wmark_chk.sv
`timescale 1ns/1ps
module rxq_wmark_chk
    import rxq_wmark_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_en,
    input logic                       wr_vld,
    input logic                       rd_stb,
    input logic                       dma_ack,
    input logic                       ie_full,
    input logic                       ie_req,
    input logic [W-1:0]               rd_data,
    input logic [STAT_W-1:0]          stat,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int CW = $clog2(DEPTH + 1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R1
    AST_FULL_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && stat[FULL_BIT] && rd_stb && !wr_vld) |=> !stat[FULL_BIT]); // R2
    AST_REQ_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && dma_ack) |=> !stat[REQ_BIT]); // R4
    AST_FLAGS_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (!stat[FULL_BIT] && !stat[REQ_BIT])); // R5
    AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (level == '0)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_full && !ie_req) |-> !irq); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && stat[OVR_BIT]) |=> stat[OVR_BIT]); // R8
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_stb) |-> (rd_data == '0)); // R9
    AST_PAIRED_ACCESS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && wr_vld && rd_stb && !dma_ack && level != '0) |=> $stable(level)); // R10

endmodule

bind rxq_wmark_top rxq_wmark_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .wr_vld  (wr_vld),
    .rd_stb  (rd_stb),
    .dma_ack (dma_ack),
    .ie_full (ie_full),
    .ie_req  (ie_req),
    .rd_data (rd_data),
    .stat    (stat),
    .irq     (irq),
    .level   (level)
);

// File: tb/sim_rxq_wmark_top.sv
`timescale 1ns/1ps
module sim_rxq_wmark_top;
    localparam int W     = 8;
    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_en = 1'b0;
    logic [1:0]   wm_sel = 2'd0;
    logic         ie_full = 1'b0, ie_req = 1'b0;
    logic         wr_vld = 1'b0, rd_stb = 1'b0, dma_ack = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [15:0]  stat;
    logic         irq;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] q[$];
    bit m_ovr  = 0;
    bit m_hold = 0;
    int thr_m  = 1;

    always #2.5 clk = ~clk;

    rxq_wmark_top #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wm_sel(wm_sel),
        .ie_full(ie_full), .ie_req(ie_req), .wr_vld(wr_vld), .wr_data(wr_data),
        .rd_stb(rd_stb), .dma_ack(dma_ack), .rd_data(rd_data), .stat(stat), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return DEPTH - 4;
        endcase
    endfunction

    // Monitor: pops the expected word when a read access is in progress
    always @(negedge clk) begin
        #2;
        if (rst_n && (rd_stb || dma_ack)) begin
            if (rx_en && q.size() > 0) chk("R1 read order", rd_data, q.pop_front());
            else                       chk("R9 empty read", rd_data, 0);
        end
    end

    // Driver: one clock cycle of stimulus, then model update and status checks
    task automatic cyc(input bit en, input bit wr, input logic [W-1:0] d,
                       input bit rd, input bit ack);
        bit ef, er;
        @(negedge clk);
        rx_en = en; wr_vld = wr; wr_data = d; rd_stb = rd; dma_ack = ack;
        @(posedge clk);
        if (en && wr) begin
            if (q.size() < DEPTH) q.push_back(d);
            else                  m_ovr = 1;
        end
        m_hold = en && ack;
        thr_m  = thr_of(wm_sel);
        if (!en) begin q.delete(); m_ovr = 0; end
        #1;
        ef = en && (q.size() == DEPTH);
        er = en && !m_hold && (q.size() > thr_m);
        chk("R2 full flag", stat[9], ef);
        chk(m_hold ? "R4 request gap" : "R3 request flag", stat[8], er);
        chk("R8 overrun", stat[0], m_ovr);
        chk("R7 other bits", stat & 16'hFCFE, 0);
        chk("R6 irq", irq, (ie_full && ef) || (ie_req && er));
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset status", stat, 0);
        chk("R6 reset irq", irq, 0);
        chk("R9 reset data", rd_data, 0);
        rst_n = 1'b1;

        // basic order, threshold 1
        wm_sel = 2'd0;
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 8'hA0 + W'(i), 0, 0);
        chk("R3 above one", stat[8], 1);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 0);
        cyc(1, 0, 0, 1, 0);                     // R9 empty read
        chk("R9 level kept", stat[8], 0);
        cyc(1, 1, 8'h55, 0, 0);
        cyc(1, 0, 0, 1, 0);                     // must return 55

        // fill to depth, overrun, paired access at full
        ie_full = 1'b1;
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, 8'h10 + W'(i), 0, 0);
        chk("R2 full at depth", stat[9], 1);
        cyc(1, 1, 8'hEE, 0, 0);
        chk("R8 overrun set", stat[0], 1);
        cyc(1, 1, 8'h77, 1, 0);
        chk("R10 still full", stat[9], 1);
        cyc(1, 0, 0, 1, 0);
        chk("R2 full cleared", stat[9], 0);

        // DMA acknowledge gap, threshold DEPTH-4
        ie_full = 1'b0; ie_req = 1'b1;
        wm_sel = 2'd3;
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1);
        chk("R4 gap after ack", stat[8], 0);
        cyc(1, 0, 0, 0, 0);
        chk("R4 reassert", stat[8], 1);
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R3 below threshold", stat[8], 0);

        // watermark change latency and boundary (level 4)
        @(negedge clk);
        wm_sel = 2'd0;
        #1;
        chk("R3 select latency", stat[8], 0);
        cyc(1, 0, 0, 0, 0);
        chk("R3 new threshold", stat[8], 1);
        wm_sel = 2'd1;
        cyc(1, 0, 0, 0, 0);
        chk("R3 equal not above", stat[8], 0);
        wm_sel = 2'd2;
        cyc(1, 1, 8'h33, 0, 0);

        // disable flushes and ignores writes
        cyc(1, 1, 8'h66, 0, 0);
        cyc(1, 1, 8'h67, 0, 0);
        cyc(1, 1, 8'h68, 0, 0);
        cyc(1, 1, 8'h69, 0, 0);
        chk("R3 above eight", stat[8], 1);
        cyc(0, 1, 8'h99, 0, 0);
        chk("R5 status off", stat, 0);
        cyc(1, 0, 0, 1, 0);                     // flushed: reads 0
        cyc(1, 1, 8'h42, 0, 0);
        cyc(1, 0, 0, 1, 0);                     // R5 only 42 present
        chk("R5 empty again", stat[8], 0);

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule